// File: doc/BRIEF.md
# Banked GPIO Unit with Separate Direction Configuration

This block provides 64 general-purpose I/O lines arranged as eight banks of eight. Line n sits in bank n/8 at bit n%8. Software reaches pin levels through a byte-wide data port. Each bank owns one data byte, and the bytes sit at consecutive addresses starting from a base address supplied at runtime. A read returns the synchronized levels seen at the pads. A write loads the bank's output latches.

Direction and function selection sit in a separate byte-wide configuration space. Each bank has a drive-enable byte. The lower five banks also have a GPIO-select byte, which hands the line to the GPIO function. The upper three banks have no select byte and are always GPIO.

A line drives its latch value only when its drive enable and its GPIO select are both set. Otherwise the line is tri-stated and a data read returns the external level. To bring a line into use, software sets its select bit, where one exists, and clears its drive-enable bit, so the line starts as an input. Bank labels count from 1, so line n is named by bank 1+n/8 and bit n%8. The labels matter only to software; the addresses below use bank index g counting from 0.

Top module: `gpio_bank_top`

## Requirements
- R1: While reset is held, and after it, every latch, drive-enable byte and GPIO-select byte is 0. pin_oe and pin_out are all 0, and every configuration read returns 0 until something is written.
- R2: A data write to address io_base+g, for g in 0..7, loads latch byte g. Bit b of that byte appears on pin_out[8g+b] one clock after the latch updates.
- R3: A data read of io_base+g returns byte g of pin_in, taken through a two-flop synchronizer. Any data access outside io_base..io_base+7 reads 0 and changes no latch.
- R4: Configuration register 0xC8+g holds the drive-enable byte of bank g and reads back what was written. Bit value 1 means drive and bit value 0 means input.
- R5: Configuration register 0xC0+g, for g in 0..4, holds the GPIO-select byte of bank g and reads back what was written.
- R6: Configuration registers 0xC5..0xC7 read 0 and ignore writes. Lines in banks 5..7 are always GPIO and drive whenever their drive-enable bit is 1.
- R7: pin_oe[n] is 1 exactly when line n's drive-enable bit and its GPIO select are both 1, one clock after the registers change. While pin_oe[n] is 0, a data read reports the external level.
- R8: Configuration addresses outside 0xC0..0xCF read 0, and writes to them change no pin.
- R9: A data write and a configuration write issued in the same clock both take effect. The pins then show the new latch value under the new drive enable.
- R10: io_base may change at runtime. After a change, accesses decode against the new base only.
- R11: The bring-up sequence (set the select bit, clear the drive-enable bit) leaves the line tri-stated, and the line's external level can then be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_base | input | 16 | Runtime base address of the data bytes |
| dp_sel | input | 1 | Data port access strobe |
| dp_wr | input | 1 | Data port write (1) or read (0) |
| dp_addr | input | 16 | Data port address |
| dp_wdata | input | 8 | Data port write byte |
| dp_rdata | output | 8 | Data port read byte, registered |
| cf_sel | input | 1 | Configuration access strobe |
| cf_wr | input | 1 | Configuration write (1) or read (0) |
| cf_addr | input | 8 | Configuration register index |
| cf_wdata | input | 8 | Configuration write byte |
| cf_rdata | output | 8 | Configuration read byte, registered |
| pin_in | input | 64 | Pad input levels |
| pin_out | output | 64 | Pad output values |
| pin_oe | output | 64 | Pad drive enables |

## Verification
The two buses are independent, so a latch update from the data port and a drive-enable or select change from the configuration port can land in the same clock. The bench provokes this with a directed case that issues both writes on the same edge. The random loop also lets the two buses collide. In every case the pad vector is compared against a model in which both updates apply. Reads are judged through a pad model: a driven line reflects its latch and an undriven line reflects the external level.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Width of one bank register and of both bus data paths.
  localparam int unsigned BANK_W = 8;
  // Select result for a configuration access.
  typedef enum logic [1:0] {CFG_MISS, CFG_SELECT, CFG_DRIVE} cfg_hit_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned GROUPS        = 8,
  parameter int unsigned SEL_GROUPS    = 5,
  parameter int unsigned CAW           = 8,
  parameter logic [7:0]  SEL_BASE      = 8'hC0,
  parameter logic [7:0]  DRV_BASE      = 8'hC8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cf_sel,
  input  logic                     cf_wr,
  input  logic [CAW-1:0]           cf_addr,
  input  logic [BANK_W-1:0]        cf_wdata,
  output logic [BANK_W-1:0]        cf_rdata,
  output logic [GROUPS*BANK_W-1:0] drv_all,
  output logic [GROUPS*BANK_W-1:0] gsel_all
);
  localparam int unsigned GIW = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic [CAW-1:0]    sel_off, drv_off;
  logic [GIW-1:0]    idx;
  cfg_hit_e          hit;
  logic [BANK_W-1:0] drv_q    [GROUPS];
  logic [BANK_W-1:0] sel_view [GROUPS];
  logic [BANK_W-1:0] rd_val;

  assign sel_off = cf_addr - CAW'(SEL_BASE);
  assign drv_off = cf_addr - CAW'(DRV_BASE);

  always_comb begin
    hit = CFG_MISS;
    idx = '0;
    if (drv_off < CAW'(GROUPS)) begin
      hit = CFG_DRIVE;
      idx = drv_off[GIW-1:0];
    end else if (sel_off < CAW'(GROUPS)) begin
      hit = CFG_SELECT;
      idx = sel_off[GIW-1:0];
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        drv_q[g] <= '0;
      else if (cf_sel && cf_wr && hit == CFG_DRIVE && idx == GIW'(g))
        drv_q[g] <= cf_wdata;
    end
    assign drv_all[g*BANK_W +: BANK_W] = drv_q[g];

    if (g < SEL_GROUPS) begin : g_sel
      logic [BANK_W-1:0] sel_q;
      always_ff @(posedge clk) begin
        if (rst)
          sel_q <= '0;
        else if (cf_sel && cf_wr && hit == CFG_SELECT && idx == GIW'(g))
          sel_q <= cf_wdata;
      end
      assign sel_view[g]                  = sel_q;
      assign gsel_all[g*BANK_W +: BANK_W] = sel_q;
    end else begin : g_fixed
      assign sel_view[g]                  = '0;
      assign gsel_all[g*BANK_W +: BANK_W] = '1;
    end
  end

  always_comb begin
    case (hit)
      CFG_DRIVE:  rd_val = drv_q[idx];
      CFG_SELECT: rd_val = sel_view[idx];
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      cf_rdata <= '0;
    else if (cf_sel && !cf_wr)
      cf_rdata <= rd_val;
  end
endmodule

// File: rtl/gpio_data_port.sv
module gpio_data_port
  import gpio_bank_pkg::*;
#(
  parameter int unsigned GROUPS = 8,
  parameter int unsigned IOAW   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [IOAW-1:0]          io_base,
  input  logic                     dp_sel,
  input  logic                     dp_wr,
  input  logic [IOAW-1:0]          dp_addr,
  input  logic [BANK_W-1:0]        dp_wdata,
  input  logic [GROUPS*BANK_W-1:0] lvl_sync,
  output logic [BANK_W-1:0]        dp_rdata,
  output logic [GROUPS*BANK_W-1:0] latch_all
);
  localparam int unsigned GIW = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic [IOAW-1:0]   offset;
  logic              hit;
  logic [GIW-1:0]    idx;
  logic [BANK_W-1:0] lvl_grp [GROUPS];

  assign offset = dp_addr - io_base;
  assign hit    = offset < IOAW'(GROUPS);
  assign idx    = offset[GIW-1:0];

  for (genvar g = 0; g < GROUPS; g++) begin : g_bank
    logic [BANK_W-1:0] latch_q;
    always_ff @(posedge clk) begin
      if (rst)
        latch_q <= '0;
      else if (dp_sel && dp_wr && hit && idx == GIW'(g))
        latch_q <= dp_wdata;
    end
    assign latch_all[g*BANK_W +: BANK_W] = latch_q;
    assign lvl_grp[g]                    = lvl_sync[g*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk) begin
    if (rst)
      dp_rdata <= '0;
    else if (dp_sel && !dp_wr)
      dp_rdata <= hit ? lvl_grp[idx] : '0;
  end
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top #(
  parameter int unsigned GROUPS     = 8,
  parameter int unsigned SEL_GROUPS = 5,
  parameter int unsigned IOAW       = 16,
  parameter int unsigned CAW        = 8,
  parameter logic [7:0]  SEL_BASE   = 8'hC0,
  parameter logic [7:0]  DRV_BASE   = 8'hC8,
  localparam int unsigned NPIN      = GROUPS * 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IOAW-1:0] io_base,
  input  logic            dp_sel,
  input  logic            dp_wr,
  input  logic [IOAW-1:0] dp_addr,
  input  logic [7:0]      dp_wdata,
  output logic [7:0]      dp_rdata,
  input  logic            cf_sel,
  input  logic            cf_wr,
  input  logic [CAW-1:0]  cf_addr,
  input  logic [7:0]      cf_wdata,
  output logic [7:0]      cf_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);
  logic [NPIN-1:0] lvl_sync;
  logic [NPIN-1:0] latch_all;
  logic [NPIN-1:0] drv_all;
  logic [NPIN-1:0] gsel_all;

  gpio_sync #(.WIDTH(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_sync)
  );

  gpio_cfg_regs #(
    .GROUPS(GROUPS), .SEL_GROUPS(SEL_GROUPS), .CAW(CAW),
    .SEL_BASE(SEL_BASE), .DRV_BASE(DRV_BASE)
  ) u_cfg (
    .clk(clk), .rst(rst), .cf_sel(cf_sel), .cf_wr(cf_wr),
    .cf_addr(cf_addr), .cf_wdata(cf_wdata), .cf_rdata(cf_rdata),
    .drv_all(drv_all), .gsel_all(gsel_all)
  );

  gpio_data_port #(.GROUPS(GROUPS), .IOAW(IOAW)) u_data (
    .clk(clk), .rst(rst), .io_base(io_base), .dp_sel(dp_sel),
    .dp_wr(dp_wr), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
    .lvl_sync(lvl_sync), .dp_rdata(dp_rdata), .latch_all(latch_all)
  );

  // Registered pad stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= latch_all;
      pin_oe  <= drv_all & gsel_all;
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NPIN     = 64,
  parameter int unsigned GROUPS   = 8,
  parameter int unsigned SEL_GROUPS = 5,
  parameter int unsigned IOAW     = 16,
  parameter int unsigned CAW      = 8,
  parameter logic [7:0]  SEL_BASE = 8'hC0,
  parameter logic [7:0]  DRV_BASE = 8'hC8
) (
  input logic            clk,
  input logic            rst,
  input logic [IOAW-1:0] io_base,
  input logic            dp_sel,
  input logic            dp_wr,
  input logic [IOAW-1:0] dp_addr,
  input logic [7:0]      dp_rdata,
  input logic            cf_sel,
  input logic            cf_wr,
  input logic [CAW-1:0]  cf_addr,
  input logic [7:0]      cf_rdata,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] drv_all
);
  logic [CAW-1:0]  sel_off, drv_off;
  logic [IOAW-1:0] d_off;
  logic            cf_rd, cf_hi_sel, cf_out, dp_miss;

  assign sel_off   = cf_addr - CAW'(SEL_BASE);
  assign drv_off   = cf_addr - CAW'(DRV_BASE);
  assign d_off     = dp_addr - io_base;
  assign cf_rd     = cf_sel && !cf_wr;
  assign cf_hi_sel = sel_off >= CAW'(SEL_GROUPS) && sel_off < CAW'(GROUPS)
                     && drv_off >= CAW'(GROUPS);
  assign cf_out    = sel_off >= CAW'(GROUPS) && drv_off >= CAW'(GROUPS);
  assign dp_miss   = dp_sel && !dp_wr && d_off >= IOAW'(GROUPS);

  AST_NO_DRIVE_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~$past(drv_all)) == '0); // R7

  AST_UPPER_SELECT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cf_rd && cf_hi_sel) |=> cf_rdata == 8'h00); // R6

  AST_CFG_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cf_rd && cf_out) |=> cf_rdata == 8'h00); // R8

  AST_DATA_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    dp_miss |=> dp_rdata == 8'h00); // R3
endmodule

bind gpio_bank_top gpio_bank_chk #(
  .NPIN(NPIN), .GROUPS(GROUPS), .SEL_GROUPS(SEL_GROUPS), .IOAW(IOAW),
  .CAW(CAW), .SEL_BASE(SEL_BASE), .DRV_BASE(DRV_BASE)
) u_chk (
  .clk(clk), .rst(rst), .io_base(io_base), .dp_sel(dp_sel), .dp_wr(dp_wr),
  .dp_addr(dp_addr), .dp_rdata(dp_rdata), .cf_sel(cf_sel), .cf_wr(cf_wr),
  .cf_addr(cf_addr), .cf_rdata(cf_rdata), .pin_oe(pin_oe), .drv_all(drv_all)
);

// File: tb/sim_gpio_bank_top.sv
module sim_gpio_bank_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_base = 16'h0290;
  logic        dp_sel = 0, dp_wr = 0, cf_sel = 0, cf_wr = 0;
  logic [15:0] dp_addr = '0;
  logic [7:0]  dp_wdata = '0, cf_wdata = '0, cf_addr = '0;
  logic [7:0]  dp_rdata, cf_rdata;
  logic [63:0] ext = '0;
  logic [63:0] pin_in, pin_out, pin_oe;

  int total = 0, fails = 0;
  logic done = 0;

  logic [7:0] m_latch [8];
  logic [7:0] m_drv   [8];
  logic [7:0] m_sel   [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pad: driven lines show their latch, others the external level.
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_bank_top u0 (
    .clk(clk), .rst(rst), .io_base(io_base), .dp_sel(dp_sel), .dp_wr(dp_wr),
    .dp_addr(dp_addr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
    .cf_sel(cf_sel), .cf_wr(cf_wr), .cf_addr(cf_addr), .cf_wdata(cf_wdata),
    .cf_rdata(cf_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [63:0] exp_oe();
    logic [63:0] v;
    for (int g = 0; g < 8; g++)
      v[g*8 +: 8] = m_drv[g] & ((g < 5) ? m_sel[g] : 8'hFF);
    return v;
  endfunction

  function automatic logic [63:0] exp_out();
    logic [63:0] v;
    for (int g = 0; g < 8; g++) v[g*8 +: 8] = m_latch[g];
    return v;
  endfunction

  function automatic logic [7:0] exp_cfg(input logic [7:0] a);
    if (a >= 8'hC8 && a <= 8'hCF) return m_drv[a - 8'hC8];
    if (a >= 8'hC0 && a <= 8'hC4) return m_sel[a - 8'hC0];
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_data(input logic [15:0] a);
    logic [15:0] off;
    logic [63:0] lvl;
    off = a - io_base;
    lvl = (exp_oe() & exp_out()) | (~exp_oe() & ext);
    if (off < 16'd8) return lvl[off[2:0]*8 +: 8];
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dwrite(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] off;
    @(negedge clk);
    dp_sel = 1; dp_wr = 1; dp_addr = a; dp_wdata = d;
    @(negedge clk);
    dp_sel = 0; dp_wr = 0;
    off = a - io_base;
    if (off < 16'd8) m_latch[off[2:0]] = d;
  endtask

  task automatic cwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cf_sel = 1; cf_wr = 1; cf_addr = a; cf_wdata = d;
    @(negedge clk);
    cf_sel = 0; cf_wr = 0;
    if (a >= 8'hC8 && a <= 8'hCF) m_drv[a - 8'hC8] = d;
    else if (a >= 8'hC0 && a <= 8'hC4) m_sel[a - 8'hC0] = d;
  endtask

  task automatic dread(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    dp_sel = 1; dp_wr = 0; dp_addr = a;
    @(negedge clk);
    dp_sel = 0;
    d = dp_rdata;
  endtask

  task automatic cread(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cf_sel = 1; cf_wr = 0; cf_addr = a;
    @(negedge clk);
    cf_sel = 0;
    d = cf_rdata;
  endtask

  task automatic check_pins(input string req);
    check(req, pin_oe, exp_oe());
    check(req, pin_out, exp_out());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd4242));
    for (int g = 0; g < 8; g++) begin m_latch[g] = 0; m_drv[g] = 0; m_sel[g] = 0; end
    idle(5);
    // R1: state while reset is held
    check("R1", pin_oe, 64'h0);
    rst = 0;
    idle(2);
    check_pins("R1");
    cread(8'hC8, rd); check("R1", rd, 8'h00);
    cread(8'hC2, rd); check("R1", rd, 8'h00);

    // R2: latch write lands on pin_out
    dwrite(io_base + 16'd3, 8'hA5); idle(2);
    check("R2", pin_out[31:24], 8'hA5);
    check_pins("R2");

    // R4 / R5 readback
    cwrite(8'hCB, 8'h3C); cread(8'hCB, rd); check("R4", rd, 8'h3C);
    cwrite(8'hC3, 8'h0F); cread(8'hC3, rd); check("R5", rd, 8'h0F);
    idle(2);
    // R7: only bits enabled by both drive and select
    check("R7", pin_oe[31:24], 8'h0C);

    // R6: upper bank select registers
    cwrite(8'hC6, 8'hFF); cread(8'hC6, rd); check("R6", rd, 8'h00);
    cwrite(8'hCE, 8'h81); dwrite(io_base + 16'd6, 8'h80); idle(2);
    check("R6", pin_oe[55:48], 8'h81);
    check("R6", pin_out[55:48], 8'h80);

    // R8: outside configuration window
    cwrite(8'h20, 8'hFF); cwrite(8'hBF, 8'hFF); cwrite(8'hD0, 8'hFF); idle(2);
    cread(8'hD0, rd); check("R8", rd, 8'h00);
    check_pins("R8");

    // R3: synchronized input read, and a miss
    ext = 64'h0123_4567_89AB_CDEF; idle(3);
    dread(io_base + 16'd0, rd); check("R3", rd, exp_data(io_base));
    dread(io_base + 16'd8, rd); check("R3", rd, 8'h00);
    dwrite(io_base - 16'd1, 8'hFF); idle(2);
    check_pins("R3");

    // R9: both buses in the same clock
    @(negedge clk);
    dp_sel = 1; dp_wr = 1; dp_addr = io_base + 16'd7; dp_wdata = 8'h5A;
    cf_sel = 1; cf_wr = 1; cf_addr = 8'hCF; cf_wdata = 8'hF0;
    @(negedge clk);
    dp_sel = 0; dp_wr = 0; cf_sel = 0; cf_wr = 0;
    m_latch[7] = 8'h5A; m_drv[7] = 8'hF0;
    idle(2);
    check("R9", pin_oe[63:56], 8'hF0);
    check("R9", pin_out[63:56], 8'h5A);

    // R10: move the base
    io_base = 16'h0A00;
    dwrite(16'h0292, 8'h77); idle(2);
    check("R10", pin_out[23:16], 8'h00);
    dwrite(16'h0A02, 8'h77); idle(2);
    check("R10", pin_out[23:16], 8'h77);

    // R11: bring-up of line 13 (bank 1, bit 5)
    cwrite(8'hC9, 8'hFF); cwrite(8'hC1, 8'hFF); idle(2);
    check("R11", pin_oe[13], 1'b1);
    cread(8'hC1, rd); cwrite(8'hC1, rd | 8'h20);
    cread(8'hC9, rd); cwrite(8'hC9, rd & ~8'h20);
    ext[13] = 1'b1; dwrite(io_base + 16'd1, 8'h00); idle(4);
    check("R11", pin_oe[13], 1'b0);
    dread(io_base + 16'd1, rd); check("R11", rd[5], 1'b1);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      int k;
      k = $urandom_range(0, 3);
      if (k == 0) dwrite(io_base + 16'($urandom_range(0, 9)) - 16'd1, 8'($urandom));
      else if (k == 1) cwrite(8'($urandom_range(8'hBE, 8'hD1)), 8'($urandom));
      else if (k == 2) ext = {$urandom, $urandom};
      else begin
        @(negedge clk);
        dp_sel = 1; dp_wr = 1; dp_addr = io_base + 16'($urandom_range(0, 7));
        dp_wdata = 8'($urandom);
        cf_sel = 1; cf_wr = 1; cf_addr = 8'($urandom_range(8'hC0, 8'hCF));
        cf_wdata = 8'($urandom);
        @(negedge clk);
        dp_sel = 0; dp_wr = 0; cf_sel = 0; cf_wr = 0;
        m_latch[dp_addr - io_base] = dp_wdata;
        if (cf_addr >= 8'hC8) m_drv[cf_addr - 8'hC8] = cf_wdata;
        else if (cf_addr <= 8'hC4) m_sel[cf_addr - 8'hC0] = cf_wdata;
      end
      idle(3);
      check_pins("R9");
      begin
        logic [15:0] a;
        logic [7:0] c;
        a = io_base + 16'($urandom_range(0, 8));
        dread(a, rd); check("R3", rd, exp_data(a));
        c = 8'($urandom_range(8'hBE, 8'hD1));
        cread(c, rd); check("R4", rd, exp_cfg(c));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule